// File: doc/BRIEF.md
# Half-Line Raster Sync Generator

This block produces the timing skeleton of a video raster, interlaced or progressive. A horizontal counter steps through the T-cycles of one half line. A vertical counter steps through the half lines of one field. A field flag flips each time the vertical counter wraps. Programmed start and stop values are compared against these counters to drive horizontal sync, vertical sync, a composite sync, a composite blanking output, an active-window flag and a border flag. The composite sync carries equalization pulses in the first half lines of the field and serration pulses while vertical sync is high.

Because vertical positions are counted in half lines, a field with an odd number of half lines makes consecutive fields start alternately at a line start and at a line midpoint. This is what an interlaced raster needs. The active window is given vertically in full lines. On an even field the first half line belongs to no full line.

Each configuration write is one 32-bit word. Bits 31:24 select the register, bits 23:12 carry the vertical field, and bits 11:0 carry the horizontal field. All outputs are registered, so each output reflects the counter state of the previous clock. The hardware does not check whether settings are sensible.

Top module: `halfline_sync_gen`

## Requirements
- R1: While `rst` is high, every output is 0, and all counters and configuration fields are cleared to zero.
- R2: The horizontal counter counts from 0 up to the value in bits 11:0 of register 0x40, then restarts at 0 (it also restarts if it is at or beyond that value). One half line therefore lasts that value plus one clocks. The half-line counter advances at each horizontal restart and returns to 0 after the half line whose number plus one reaches bits 23:12 of register 0x40.
- R3: `hsync` is set when the horizontal count equals bits 11:0 of register 0x41 and cleared when it equals bits 11:0 of register 0x42. Set wins when both values are equal.
- R4: `vsync` changes only at a half-line start (horizontal count 0). It is set when the half-line count equals bits 23:12 of register 0x41 and cleared when it equals bits 23:12 of register 0x42. Set wins.
- R5: While the half-line count is below bits 23:12 of register 0x46, `csync` is high exactly while the horizontal count is below bits 11:0 of register 0x46. This gives an equalization pulse at the start of every half line.
- R6: Outside the equalization period, while vertical sync is high, `csync` is high from the horizontal count in bits 11:0 of register 0x45 up to the end of the half line.
- R7: Outside both of those periods, `csync` follows `hsync`.
- R8: `blank` is the OR of a horizontal blanking state and a vertical blanking state. The horizontal state is set and cleared at the T-cycle positions in bits 11:0 of registers 0x43 and 0x44. The vertical state is set and cleared at half-line starts, at the half-line positions in bits 23:12 of the same registers.
- R9: `active` is high when the horizontal count lies in [bits 11:0 of 0x47, bits 11:0 of 0x48) and the full-line number lies in [bits 23:12 of 0x47, bits 23:12 of 0x48). The full-line number is half-line/2 on an odd field and (half-line−1)/2 on an even field. Half line 0 of an even field is never active.
- R10: `border` is high exactly when neither `active` nor `blank` is high.
- R11: `fieldEven` starts at 0 (odd field) and inverts at every field wrap.
- R12: A write whose address byte lies outside 0x40..0x48 changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-cycle per period |
| rst | input | 1 | Synchronous reset, active high |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWord | input | 32 | Address byte, vertical field, horizontal field |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| csync | output | 1 | Composite sync with equalization and serration |
| blank | output | 1 | Composite blanking |
| active | output | 1 | Inside the active window |
| border | output | 1 | Outside the window and not blanked |
| fieldEven | output | 1 | High during an even field |

## Verification
The hardest case to reach from the ports is an even field. On an even field the full-line numbering shifts by one half line, and vertical sync or blanking may straddle the field wrap. This only happens after many half lines, and only with an odd half-line total. The stimulus therefore uses short random half lines and small, mostly odd field sizes, so that many fields pass in each configuration. Random start and stop values, including swapped and equal ones, are mixed with one directed interlaced setup and with writes to addresses outside the register range.

// File: rtl/hsg_pkg.sv
package hsg_pkg;
  localparam int CW = 12;

  // register offsets from the address base
  localparam logic [7:0] OFS_BASE    = 8'd0;
  localparam logic [7:0] OFS_SYNC_ON = 8'd1;
  localparam logic [7:0] OFS_SYNC_OF = 8'd2;
  localparam logic [7:0] OFS_BLK_ON  = 8'd3;
  localparam logic [7:0] OFS_BLK_OF  = 8'd4;
  localparam logic [7:0] OFS_SERR    = 8'd5;
  localparam logic [7:0] OFS_EQU     = 8'd6;
  localparam logic [7:0] OFS_ACT_ON  = 8'd7;
  localparam logic [7:0] OFS_ACT_OF  = 8'd8;

  typedef struct packed {
    logic [CW-1:0] hsOn, hsOff, vsOn, vsOff;
    logic [CW-1:0] hbOn, hbOff, vbOn, vbOff;
    logic [CW-1:0] serOn, eqH, eqV;
    logic [CW-1:0] ahOn, ahOff, avOn, avOff;
  } evCfg_t;

  typedef struct packed {
    logic lineStart;
    logic fieldWrap;
  } tick_t;
endpackage

// File: rtl/hsg_ctrl.sv
module hsg_ctrl
  import hsg_pkg::*;
#(
  parameter logic [7:0] ADDR_BASE = 8'h40
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfgWrEn,
  input  logic [31:0]   cfgWord,
  output evCfg_t        cfg,
  output logic [CW-1:0] hCnt,
  output logic [CW-1:0] halfCnt,
  output logic          evenField,
  output tick_t         tick
);
  logic [CW-1:0] hMax, halfTotal;
  logic [CW-1:0] vField, hField;
  logic [7:0]    regSel;
  logic          hEnd, lastHalf;

  assign vField = cfgWord[2*CW-1:CW];
  assign hField = cfgWord[CW-1:0];
  assign regSel = cfgWord[31:24] - ADDR_BASE;

  always_ff @(posedge clk) begin
    if (rst) begin
      hMax      <= '0;
      halfTotal <= '0;
      cfg       <= '0;
    end else if (cfgWrEn) begin
      case (regSel)
        OFS_BASE:    begin hMax <= hField;      halfTotal <= vField; end
        OFS_SYNC_ON: begin cfg.hsOn <= hField;  cfg.vsOn <= vField;  end
        OFS_SYNC_OF: begin cfg.hsOff <= hField; cfg.vsOff <= vField; end
        OFS_BLK_ON:  begin cfg.hbOn <= hField;  cfg.vbOn <= vField;  end
        OFS_BLK_OF:  begin cfg.hbOff <= hField; cfg.vbOff <= vField; end
        OFS_SERR:    cfg.serOn <= hField;
        OFS_EQU:     begin cfg.eqH <= hField;   cfg.eqV <= vField;   end
        OFS_ACT_ON:  begin cfg.ahOn <= hField;  cfg.avOn <= vField;  end
        OFS_ACT_OF:  begin cfg.ahOff <= hField; cfg.avOff <= vField; end
        default: ;
      endcase
    end
  end

  assign hEnd     = (hCnt >= hMax);
  assign lastHalf = (({1'b0, halfCnt} + 13'd1) >= {1'b0, halfTotal});

  always_ff @(posedge clk) begin
    if (rst) begin
      hCnt      <= '0;
      halfCnt   <= '0;
      evenField <= 1'b0;
    end else if (hEnd) begin
      hCnt <= '0;
      if (lastHalf) begin
        halfCnt   <= '0;
        evenField <= ~evenField;
      end else begin
        halfCnt <= halfCnt + 1'b1;
      end
    end else begin
      hCnt <= hCnt + 1'b1;
    end
  end

  assign tick.lineStart = (hCnt == '0);
  assign tick.fieldWrap = hEnd && lastHalf;

  a_r2_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    hEnd |=> (hCnt == '0));
  a_r2_half_step: assert property (@(posedge clk) disable iff (rst)
    (hEnd && !lastHalf) |=> (halfCnt == $past(halfCnt) + 1'b1));
  a_r11_field_flip: assert property (@(posedge clk) disable iff (rst)
    (hEnd && lastHalf) |=> (evenField != $past(evenField)));
endmodule

// File: rtl/hsg_datapath.sv
module hsg_datapath
  import hsg_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  evCfg_t        cfg,
  input  logic [CW-1:0] hCnt,
  input  logic [CW-1:0] halfCnt,
  input  logic          evenField,
  input  tick_t         tick,
  output logic          hsync,
  output logic          vsync,
  output logic          csync,
  output logic          blank,
  output logic          active,
  output logic          border,
  output logic          fieldEven
);
  logic          hbQ, vbQ;
  logic          hsNext, vsNext, hbNext, vbNext, csNext, actNext, blankNext;
  logic          eqPeriod, lineValid;
  logic [CW-1:0] halfAdj, fullLine;

  always_comb begin
    hsNext = (hCnt == cfg.hsOn) ? 1'b1 : (hCnt == cfg.hsOff) ? 1'b0 : hsync;
    hbNext = (hCnt == cfg.hbOn) ? 1'b1 : (hCnt == cfg.hbOff) ? 1'b0 : hbQ;
    vsNext = vsync;
    vbNext = vbQ;
    if (tick.lineStart) begin
      vsNext = (halfCnt == cfg.vsOn) ? 1'b1 : (halfCnt == cfg.vsOff) ? 1'b0 : vsync;
      vbNext = (halfCnt == cfg.vbOn) ? 1'b1 : (halfCnt == cfg.vbOff) ? 1'b0 : vbQ;
    end
    eqPeriod = (halfCnt < cfg.eqV);
    if (eqPeriod)    csNext = (hCnt < cfg.eqH);
    else if (vsNext) csNext = (hCnt >= cfg.serOn);
    else             csNext = hsNext;
    lineValid = !(evenField && (halfCnt == '0));
    halfAdj   = evenField ? (halfCnt - 1'b1) : halfCnt;
    fullLine  = {1'b0, halfAdj[CW-1:1]};
    actNext   = lineValid && (fullLine >= cfg.avOn) && (fullLine < cfg.avOff)
                && (hCnt >= cfg.ahOn) && (hCnt < cfg.ahOff);
    blankNext = hbNext || vbNext;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync <= 1'b0; vsync <= 1'b0; csync <= 1'b0;
      hbQ <= 1'b0; vbQ <= 1'b0; blank <= 1'b0;
      active <= 1'b0; border <= 1'b0; fieldEven <= 1'b0;
    end else begin
      hsync     <= hsNext;
      vsync     <= vsNext;
      csync     <= csNext;
      hbQ       <= hbNext;
      vbQ       <= vbNext;
      blank     <= blankNext;
      active    <= actNext;
      border    <= !actNext && !blankNext;
      fieldEven <= evenField;
    end
  end

  a_r3_hsync_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(hsync) |-> ($past(hCnt) == $past(cfg.hsOn)));
  a_r4_vsync_at_line: assert property (@(posedge clk) disable iff (rst)
    $rose(vsync) |-> $past(tick.lineStart));
  a_r5_eq_pulse: assert property (@(posedge clk) disable iff (rst)
    (tick.lineStart && (halfCnt < cfg.eqV) && (cfg.eqH != '0)) |=> csync);
  a_r10_border_excl: assert property (@(posedge clk) disable iff (rst)
    border |-> (!blank && !active));
  a_r11_field_out: assert property (@(posedge clk) disable iff (rst)
    tick.fieldWrap |=> ##1 (fieldEven != $past(fieldEven)));
endmodule

// File: rtl/halfline_sync_gen.sv
module halfline_sync_gen #(
  parameter logic [7:0] ADDR_BASE = 8'h40
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfgWrEn,
  input  logic [31:0] cfgWord,
  output logic        hsync,
  output logic        vsync,
  output logic        csync,
  output logic        blank,
  output logic        active,
  output logic        border,
  output logic        fieldEven
);
  import hsg_pkg::*;

  evCfg_t        cfg;
  tick_t         tick;
  logic [CW-1:0] hCnt, halfCnt;
  logic          evenField;

  hsg_ctrl #(.ADDR_BASE(ADDR_BASE)) u_ctrl (
    .clk(clk), .rst(rst), .cfgWrEn(cfgWrEn), .cfgWord(cfgWord),
    .cfg(cfg), .hCnt(hCnt), .halfCnt(halfCnt), .evenField(evenField), .tick(tick)
  );

  hsg_datapath u_dp (
    .clk(clk), .rst(rst), .cfg(cfg), .hCnt(hCnt), .halfCnt(halfCnt),
    .evenField(evenField), .tick(tick),
    .hsync(hsync), .vsync(vsync), .csync(csync), .blank(blank),
    .active(active), .border(border), .fieldEven(fieldEven)
  );
endmodule

// File: tb/tb_halfline_sync_gen.sv
module tb_halfline_sync_gen;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfgWrEn = 1'b0;
  logic [31:0] cfgWord = '0;
  logic hsync, vsync, csync, blank, active, border, fieldEven;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  halfline_sync_gen dut (
    .clk(clk), .rst(rst), .cfgWrEn(cfgWrEn), .cfgWord(cfgWord),
    .hsync(hsync), .vsync(vsync), .csync(csync), .blank(blank),
    .active(active), .border(border), .fieldEven(fieldEven)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  int mH [0:8];
  int mV [0:8];
  int mh, mhalf;
  bit mfld, mhs, mvs, mhb, mvb;
  bit eHs, eVs, eCs, eBlank, eAct, eBorder, eFld;
  string csTag = "R7";

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 9; i++) begin mH[i] = 0; mV[i] = 0; end
      mh = 0; mhalf = 0; mfld = 0;
      mhs = 0; mvs = 0; mhb = 0; mvb = 0;
      eHs = 0; eVs = 0; eCs = 0; eBlank = 0; eAct = 0; eBorder = 0; eFld = 0;
    end else begin
      bit ls, nhs, nvs, nhb, nvb, ncs, nact, lineOk;
      int ln;
      ls  = (mh == 0);
      nhs = (mh == mH[1]) ? 1'b1 : (mh == mH[2]) ? 1'b0 : mhs;
      nhb = (mh == mH[3]) ? 1'b1 : (mh == mH[4]) ? 1'b0 : mhb;
      nvs = mvs; nvb = mvb;
      if (ls) begin
        nvs = (mhalf == mV[1]) ? 1'b1 : (mhalf == mV[2]) ? 1'b0 : mvs;
        nvb = (mhalf == mV[3]) ? 1'b1 : (mhalf == mV[4]) ? 1'b0 : mvb;
      end
      if (mhalf < mV[6]) begin ncs = (mh < mH[6]); csTag = "R5"; end
      else if (nvs)      begin ncs = (mh >= mH[5]); csTag = "R6"; end
      else               begin ncs = nhs; csTag = "R7"; end
      lineOk = !(mfld && mhalf == 0);
      ln = mfld ? (mhalf - 1) / 2 : mhalf / 2;
      nact = lineOk && ln >= mV[7] && ln < mV[8] && mh >= mH[7] && mh < mH[8];
      eHs = nhs; eVs = nvs; eCs = ncs; eAct = nact;
      eBlank = nhb | nvb; eBorder = !nact && !(nhb | nvb); eFld = mfld;
      mhs = nhs; mvs = nvs; mhb = nhb; mvb = nvb;
      if (mh >= mH[0]) begin
        mh = 0;
        if (mhalf + 1 >= mV[0]) begin mhalf = 0; mfld = !mfld; end
        else mhalf = mhalf + 1;
      end else begin
        mh = mh + 1;
      end
      if (cfgWrEn && cfgWord[31:24] >= 8'h40 && cfgWord[31:24] <= 8'h48) begin
        mH[cfgWord[27:24]] = int'(cfgWord[11:0]);
        mV[cfgWord[27:24]] = int'(cfgWord[23:12]);
      end
    end
  end

  task automatic check(input bit act, input bit exp, input string tag, input string nm);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s cycle %0d: got %0b expected %0b", tag, nm, cyc, act, exp);
    end
  endtask

  task automatic compareAll();
    check(hsync, eHs, "R3", "hsync");
    check(vsync, eVs, "R4", "vsync");
    check(csync, eCs, csTag, "csync");
    check(blank, eBlank, "R8", "blank");
    check(active, eAct, "R9", "active");
    check(border, eBorder, "R10", "border");
    check(fieldEven, eFld, "R11", "fieldEven");
  endtask

  task automatic step(input bit we, input logic [31:0] w);
    @(negedge clk);
    cyc++;
    if (!rst) compareAll();
    cfgWrEn = we;
    cfgWord = w;
  endtask

  task automatic wr(input logic [7:0] a, input int v, input int h);
    step(1'b1, {a, v[11:0], h[11:0]});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int r1, r2, base, snap;
    bit prevHs;
    void'($urandom(32'd2024));
    // R1: reset state
    repeat (3) @(negedge clk);
    check(hsync | vsync | csync | blank | active | border | fieldEven, 1'b0, "R1", "outputs in reset");
    rst = 1'b0;

    // directed interlaced setup: 20 T-cycles per half line, 25 half lines per field
    wr(8'h40, 25, 19);
    wr(8'h41, 6, 2);
    wr(8'h42, 12, 6);
    wr(8'h43, 0, 18);
    wr(8'h44, 8, 3);
    wr(8'h45, 0, 14);
    wr(8'h46, 6, 3);
    wr(8'h47, 5, 5);
    wr(8'h48, 11, 17);
    idle(25 * 20 * 3);

    // R2: half-line period seen through hsync rising edges
    prevHs = hsync; r1 = -1; r2 = -1;
    for (int i = 0; i < 100 && r2 < 0; i++) begin
      step(1'b0, '0);
      if (hsync && !prevHs) begin
        if (r1 < 0) r1 = cyc; else r2 = cyc;
      end
      prevHs = hsync;
    end
    checks++;
    if (r2 - r1 != 20) begin
      fails++;
      $display("FAIL R2 half-line period: got %0d expected %0d", r2 - r1, 20);
    end

    // R12: writes to addresses outside the register range
    snap = fails;
    wr(8'h49, 3, 1);
    wr(8'h3F, 1, 0);
    wr(8'hC0, 2, 2);
    wr(8'h50, 4095, 4095);
    idle(60);
    checks++;
    if (fails != snap) begin
      fails++;
      $display("FAIL R12 stray writes: got %0d mismatches expected 0", fails - 1 - snap);
    end

    // equal start and stop values: set wins (R3, R4)
    wr(8'h41, 2, 4);
    wr(8'h42, 2, 4);
    idle(300);

    // random configurations
    for (int k = 0; k < 40; k++) begin
      int hm, ht;
      hm = $urandom_range(13, 2);
      ht = $urandom_range(17, 3) | 1;
      if (k % 5 == 4) ht = ht + 1;
      wr(8'h40, ht, hm);
      for (int a = 1; a <= 8; a++) begin
        int vv, hh;
        hh = $urandom_range(hm + 1, 0);
        vv = (a >= 7) ? $urandom_range(ht / 2 + 1, 0) : $urandom_range(ht, 0);
        if (a == 6) vv = $urandom_range(ht / 3 + 1, 0);
        wr(8'h40 + a[7:0], vv, hh);
      end
      if ($urandom_range(3, 0) == 0) wr(8'h4F, $urandom_range(4095, 0), $urandom_range(4095, 0));
      idle(ht * (hm + 1) * 3 + 10);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule